// File: doc/BRIEF.md
# SDRAM Data Mask Pipeline

This block sits between the command decoder of a synchronous DRAM and its data pads. It turns the data mask pins into per-byte write strobes and per-byte output enables. It also delays the array read data by the programmed CAS latency, so that data leaves the device in the cycle the host expects.

During a write data cycle the mask acts at once. A lane whose mask bit is low gets a strobe, and a lane whose mask bit is high is left untouched.

During reads the mask works as an output enable, two cycles after it is sampled. An enable is only given in a cycle that carries valid read data. The 16-bit organisation has two independent mask bits, one for the lower byte and one for the upper byte. Narrower organisations use one mask bit that covers the whole word.

The active latency is held in a register. That register follows the latency input only while no read is in flight.

Top module: `sdram_dqm_pipe`

## Requirements
- R1: In a write data cycle (`wr_phase` high), `wr_strb[i]` is high in that same cycle exactly when `dqm[i]` is low.
- R2: With `wr_phase` low, every `wr_strb` bit is low, whatever the mask.
- R3: A read command (`rd_cmd` high) in cycle k gives `rd_valid` high in cycle k+L and in no other cycle, where L is the active latency. `rd_data` then equals the `arr_rdata` value sampled with the command.
- R4: In a cycle with `rd_valid` high, `rd_oe[i]` equals the inverse of `dqm[i]` as sampled two cycles earlier.
- R5: In any cycle with `rd_valid` low, every `rd_oe` bit is low, whatever the mask.
- R6: With two lanes, `dqm[0]` governs only bits 7:0 (lane 0) and `dqm[1]` governs only bits 15:8 (lane 1).
- R7: With one lane, the single mask bit governs the whole data word.
- R8: A new value on `cas_lat` is taken as the active latency only in a cycle with no read command and no read in flight. A read already issued completes with the latency that was active when it was issued.
- R9: A `cas_lat` value of 0, or a value above the maximum latency, is ignored and the active latency is kept.
- R10: After reset `rd_valid` and all `rd_oe` bits are low, and the active latency is 3.
- R11: Read commands in consecutive cycles give consecutive valid cycles with no gap. Each valid cycle carries the data of its own command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| rd_cmd | input | 1 | Read command accepted this cycle |
| wr_phase | input | 1 | Write data cycle |
| dqm | input | LANES | Mask bits, one per lane |
| cas_lat | input | CLW | Requested CAS latency (1..CL_MAX) |
| arr_rdata | input | DATA_W | Array read data, valid with `rd_cmd` |
| wr_strb | output | LANES | Per-lane write strobe |
| rd_oe | output | LANES | Per-lane output enable |
| rd_valid | output | 1 | Aligned read data valid |
| rd_data | output | DATA_W | Read data aligned to the latency |

## Verification
The bench builds two instances side by side from the same stimulus. The first is the 16-bit, two-lane variant with default parameters. The second is an 8-bit, single-lane variant whose mask is the lower mask bit of the first.

Comparing the two instances shows that each mask bit of the two-lane variant keeps to its own byte, while the single mask of the narrow variant covers the whole word. Both instances use a maximum latency of 3, so every latency setting (1, 2 and 3) can be tested. The bench also sets illegal values and changes the latency while a read is in flight.

// File: rtl/sdram_dqm_pipe.sv
module sdram_dqm_pipe #(
  parameter int DATA_W = 16,
  parameter int LANES  = 2,
  parameter int CL_MAX = 3,
  localparam int CLW   = $clog2(CL_MAX + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_cmd,
  input  logic              wr_phase,
  input  logic [LANES-1:0]  dqm,
  input  logic [CLW-1:0]    cas_lat,
  input  logic [DATA_W-1:0] arr_rdata,
  output logic [LANES-1:0]  wr_strb,
  output logic [LANES-1:0]  rd_oe,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data
);

  logic [CL_MAX:1]    vld_q;
  logic [DATA_W-1:0]  dat_q [CL_MAX:1];
  logic [LANES-1:0]   msk1_q, msk2_q;
  logic [CLW-1:0]     cl_q;
  logic               busy, cl_ok;

  assign busy  = rd_cmd | (|vld_q);
  assign cl_ok = (cas_lat != '0) && (int'(cas_lat) <= CL_MAX);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      vld_q  <= '0;
      msk1_q <= '1;
      msk2_q <= '1;
      cl_q   <= CLW'(CL_MAX);
    end else begin
      vld_q  <= {vld_q[CL_MAX-1:1], rd_cmd};
      msk1_q <= dqm;
      msk2_q <= msk1_q;
      if (!busy && cl_ok) cl_q <= cas_lat;
    end

  always_ff @(posedge clk) begin
    dat_q[1] <= arr_rdata;
    for (int s = 2; s <= CL_MAX; s++) dat_q[s] <= dat_q[s-1];
  end

  assign rd_valid = vld_q[cl_q];
  assign rd_data  = dat_q[cl_q];

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign wr_strb[g] = wr_phase & ~dqm[g];
    assign rd_oe[g]   = rd_valid & ~msk2_q[g];
  end

endmodule

// File: rtl/sdram_dqm_pipe_chk.sv
module sdram_dqm_pipe_chk #(
  parameter int DATA_W = 16,
  parameter int LANES  = 2,
  parameter int CL_MAX = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             rd_cmd,
  input logic             wr_phase,
  input logic [LANES-1:0] dqm,
  input logic [LANES-1:0] wr_strb,
  input logic [LANES-1:0] rd_oe,
  input logic             rd_valid
);

  int unsigned since_rd;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) since_rd <= CL_MAX + 1;
    else if (rd_cmd) since_rd <= 1;
    else if (since_rd <= CL_MAX) since_rd <= since_rd + 1;

  assert_strb_unmasked_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_strb & dqm) == '0);

  assert_no_strb_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_phase |-> wr_strb == '0);

  assert_valid_window_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> (since_rd >= 1 && since_rd <= CL_MAX));

  assert_read_mask_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> (rd_oe & $past(dqm, 2)) == '0);

  assert_oe_needs_valid_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_valid |-> rd_oe == '0);

endmodule

bind sdram_dqm_pipe sdram_dqm_pipe_chk #(.DATA_W(DATA_W), .LANES(LANES), .CL_MAX(CL_MAX)) u_chk (.*);

// File: tb/test_sdram_dqm_pipe.sv
module test_sdram_dqm_pipe;
  logic        clk = 0, rst_n = 0;
  logic        rd_cmd = 0, wr_phase = 0;
  logic [1:0]  dqm = 0, cas_lat = 0;
  logic [15:0] arr_rdata = 0;
  logic [1:0]  wr_strb, rd_oe;
  logic        rd_valid;
  logic [15:0] rd_data;
  logic [0:0]  n_strb, n_oe;
  logic        n_valid;
  logic [7:0]  n_data;
  int checks = 0, fails = 0;
  bit done = 0;

  always #2 clk = ~clk;

  sdram_dqm_pipe i_sdram_dqm_pipe (.clk, .rst_n, .rd_cmd, .wr_phase, .dqm, .cas_lat,
    .arr_rdata, .wr_strb, .rd_oe, .rd_valid, .rd_data);

  sdram_dqm_pipe #(.DATA_W(8), .LANES(1)) i_narrow (.clk, .rst_n, .rd_cmd, .wr_phase,
    .dqm(dqm[0:0]), .cas_lat, .arr_rdata(arr_rdata[7:0]), .wr_strb(n_strb), .rd_oe(n_oe),
    .rd_valid(n_valid), .rd_data(n_data));

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic idle(input int n);
    rd_cmd = 0;
    repeat (n) step();
  endtask

  task automatic read_case(input int c, input logic [15:0] d, input logic [11:0] mseq);
    logic [1:0] em;
    cas_lat = 2'(c);
    idle(6);
    dqm = mseq[1:0]; step();
    rd_cmd = 1; arr_rdata = d; dqm = mseq[3:2]; step();
    rd_cmd = 0; arr_rdata = 16'h0;
    em = ~mseq[2*(c-1) +: 2];
    for (int i = 1; i <= 4; i++) begin
      dqm = mseq[2*(i+1) +: 2];
      chk(rd_valid == (i == c), "R3 valid timing", rd_valid, i == c);
      chk(n_valid == (i == c), "R3 valid timing narrow", n_valid, i == c);
      if (i == c) begin
        chk(rd_data == d, "R3 data", rd_data, d);
        chk(rd_oe == em, "R4 R6 lane enables", rd_oe, em);
        chk(n_data == d[7:0], "R7 narrow data", n_data, d[7:0]);
        chk(n_oe[0] == em[0], "R7 narrow enable", n_oe, em[0]);
      end else begin
        chk(rd_oe == 2'b00, "R5 oe idle", rd_oe, 0);
        chk(n_oe == 1'b0, "R5 narrow oe idle", n_oe, 0);
      end
      step();
    end
    dqm = 0;
  endtask

  task automatic reset_case();
    cas_lat = 0;
    chk(rd_valid == 0 && rd_oe == 0, "R10 reset outputs", {rd_valid, rd_oe}, 0);
    rst_n = 1;
    idle(4);
    rd_cmd = 1; arr_rdata = 16'hA55A; step();
    rd_cmd = 0;
    for (int i = 1; i <= 4; i++) begin
      chk(rd_valid == (i == 3), "R10 R9 default latency 3", rd_valid, i == 3);
      step();
    end
  endtask

  task automatic write_case();
    wr_phase = 1; dqm = 2'b01; #1;
    chk(wr_strb == 2'b10, "R1 R6 upper strobe", wr_strb, 2'b10);
    chk(n_strb == 1'b0, "R7 narrow blocked", n_strb, 0);
    dqm = 2'b10; #1;
    chk(wr_strb == 2'b01, "R1 R6 lower strobe", wr_strb, 2'b01);
    chk(n_strb == 1'b1, "R7 narrow written", n_strb, 1);
    dqm = 2'b00; #1;
    chk(wr_strb == 2'b11, "R1 both strobes", wr_strb, 2'b11);
    wr_phase = 0; #1;
    chk(wr_strb == 2'b00 && n_strb == 0, "R2 no strobe idle", wr_strb, 0);
    dqm = 2'b11; step();
  endtask

  task automatic cl_change_case();
    cas_lat = 3; idle(6);
    rd_cmd = 1; arr_rdata = 16'h1234; step();
    rd_cmd = 0; cas_lat = 1;
    for (int i = 1; i <= 4; i++) begin
      chk(rd_valid == (i == 3), "R8 latency held in flight", rd_valid, i == 3);
      step();
    end
    idle(4);
    rd_cmd = 1; arr_rdata = 16'h4321; step();
    rd_cmd = 0;
    chk(rd_valid == 1 && rd_data == 16'h4321, "R8 new latency applied", rd_data, 16'h4321);
    step();
  endtask

  task automatic illegal_cl_case();
    cas_lat = 2; idle(6);
    cas_lat = 0; idle(4);
    rd_cmd = 1; arr_rdata = 16'h0F0F; step();
    rd_cmd = 0;
    for (int i = 1; i <= 3; i++) begin
      chk(rd_valid == (i == 2), "R9 zero latency ignored", rd_valid, i == 2);
      step();
    end
  endtask

  task automatic b2b_case();
    cas_lat = 2; dqm = 0; idle(6);
    rd_cmd = 1; arr_rdata = 16'hAAAA; step();
    arr_rdata = 16'hBBBB; step();
    rd_cmd = 0;
    chk(rd_valid && rd_data == 16'hAAAA, "R11 first beat", rd_data, 16'hAAAA);
    step();
    chk(rd_valid && rd_data == 16'hBBBB, "R11 second beat", rd_data, 16'hBBBB);
    step();
    chk(!rd_valid, "R11 end of burst", rd_valid, 0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    reset_case();
    write_case();
    read_case(1, 16'hC3A1, 12'b11_10_01_00_11_10);
    read_case(2, 16'h5E7D, 12'b00_11_01_10_11_00);
    read_case(3, 16'h9B24, 12'b11_01_10_00_11_00);
    read_case(3, 16'h7001, 12'b00_00_11_11_11_00);
    cl_change_case();
    illegal_cl_case();
    b2b_case();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule